// File: doc/BRIEF.md
# Auxiliary System Control Register File

This block holds the small control registers that a workstation I/O companion chip places beside its main functions. There are three plain byte registers (configuration, diagnostic, modem control), a miscellaneous-function byte, a software power-down byte, a 16-bit LED register and a 32-bit system control word. A host bus reaches them through a simple per-register select with a size code and an offset.

Four registered outputs come from the writes and from one external status input. The first is a power-fail interrupt. The second is a one-cycle floppy terminal-count pulse. The third is a power-off request and the fourth is a system reset request. A power-failing input sets a sticky status bit, but only while the configuration register enables it. The terminal-count strobe is never stored. The clear and power-off bits act on the write itself.

Top module: `auxctl_regfile`

## Requirements
- R1: After a synchronous reset, the configuration, modem, miscellaneous and power-down registers read 0. The interrupt, terminal-count, power-off and system-reset outputs are all low.
- R2: The diagnostic, LED and system control registers keep their contents through reset.
- R3: The power-fail status (power-down bit 5) changes only when the power-failing input changes value. It becomes input AND configuration bit 3, using the configuration value in effect after any write in the same cycle. That input update overrides a power-down write made in the same cycle.
- R4: `irq_pwrfail` is high exactly when power-down bit 5 and configuration bit 3 are both set. It follows the clock edge that updates either of them.
- R5: A power-down write stores only data bit 0 and keeps the current status bit 5. If data bit 1 is set, the status is cleared. Bit 1 and all other bits always read 0.
- R6: A power-down write with data bit 0 set raises `poweroff_req` on the same edge. The request stays high until reset.
- R7: A miscellaneous write stores the data with bit 1 forced to 0. When data bit 1 is set, `fdd_tc` is high for exactly the one cycle after the write edge.
- R8: A system control write with data bit 0 set loads the register with 0x00000002 and raises `sysrst_req`, which stays high until reset. A write with bit 0 clear changes nothing.
- R9: Every register responds only at offset 0. Writes at other offsets are ignored, and reads at other offsets return 0.
- R10: Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The byte registers need code 0, LED needs code 1 and system control needs code 2. A wrong size is ignored on write and reads 0.
- R11: Register select codes are: 0 configuration, 1 diagnostic, 2 modem, 3 miscellaneous, 4 power-down, 5 LED, 6 system control. Code 7 always reads 0.
- R12: `bus_rdata` carries the zero-extended register value in the cycle after a read strobe, and 0 after any cycle without one. Configuration, diagnostic and modem store all 8 bits, and LED stores all 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Register select code |
| bus_size | input | 2 | Access size code |
| bus_off | input | 2 | Byte offset within the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwr_failing | input | 1 | External power-failing level |
| irq_pwrfail | output | 1 | Power-fail interrupt |
| fdd_tc | output | 1 | Floppy terminal-count pulse |
| poweroff_req | output | 1 | Latched power-off request |
| sysrst_req | output | 1 | Latched system reset request |

## Verification
The bench aims at the power-fail status as a sticky bit. It disables the enable while the status is set and expects the interrupt to drop while the status still reads back. A design that tied the status to the input level would lose it. The bench also writes the clear bit and checks that bit 1 never reads back. It writes the miscellaneous strobe and checks that the pulse lasts one cycle and the stored byte has bit 1 clear, which catches a design that latches it. Randomised accesses with wrong sizes, nonzero offsets and select code 7 catch any decode that lets them write or return data. A reset after writing the diagnostic and system control registers catches a design that clears them.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
  typedef enum logic [2:0] {
    RID_CFG    = 3'd0,
    RID_DIAG   = 3'd1,
    RID_MODEM  = 3'd2,
    RID_MISC   = 3'd3,
    RID_PWRDN  = 3'd4,
    RID_LED    = 3'd5,
    RID_SYSCTL = 3'd6,
    RID_NONE   = 3'd7
  } reg_id_e;

  typedef enum logic [1:0] {
    ACC_B1  = 2'd0,
    ACC_B2  = 2'd1,
    ACC_B4  = 2'd2,
    ACC_BAD = 2'd3
  } acc_size_e;

  localparam int NUM_REGS      = 7;
  localparam int CFG_PFEN_BIT  = 3;
  localparam int PD_OFF_BIT    = 0;
  localparam int PD_CLR_BIT    = 1;
  localparam int PD_STAT_BIT   = 5;
  localparam int MISC_TC_BIT   = 1;
  localparam int SYS_RST_BIT   = 0;
  localparam int SYS_FLAG_BIT  = 1;

  function automatic acc_size_e need_size(reg_id_e r);
    case (r)
      RID_LED:    need_size = ACC_B2;
      RID_SYSCTL: need_size = ACC_B4;
      default:    need_size = ACC_B1;
    endcase
  endfunction
endpackage

// File: rtl/auxctl_decode.sv
module auxctl_decode
  import auxctl_pkg::*;
#(
  parameter int NREG = NUM_REGS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      sel,
  input  logic [1:0]      size,
  input  logic [1:0]      off,
  input  logic            wr,
  input  logic            rd,
  output logic [NREG-1:0] wr_en,
  output logic [NREG-1:0] rd_en
);
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam reg_id_e RID = reg_id_e'(i);
    logic hit;
    assign hit      = (sel == RID) && (size == need_size(RID)) && (off == 2'd0);
    assign wr_en[i] = wr && hit;
    assign rd_en[i] = rd && hit;
  end

  // R10
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_en));
  // R9
  off_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (off != 2'd0) |-> (wr_en == '0 && rd_en == '0));
endmodule

// File: rtl/auxctl_power.sv
module auxctl_power
  import auxctl_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             pd_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             pf_in,
  output logic [REG_W-1:0] cfg_q,
  output logic [REG_W-1:0] pd_val,
  output logic             irq,
  output logic             poweroff
);
  logic             pf_q, stat_q, off_q;
  logic [REG_W-1:0] cfg_n;
  logic             stat_n, off_n;

  always_comb begin
    cfg_n  = cfg_wr ? wdata : cfg_q;
    stat_n = stat_q;
    off_n  = off_q;
    if (pd_wr) begin
      off_n = wdata[PD_OFF_BIT];
      if (wdata[PD_CLR_BIT]) stat_n = 1'b0;
    end
    if (pf_in != pf_q) stat_n = pf_in & cfg_n[CFG_PFEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      stat_q   <= 1'b0;
      off_q    <= 1'b0;
      pf_q     <= 1'b0;
      irq      <= 1'b0;
      poweroff <= 1'b0;
    end else begin
      cfg_q    <= cfg_n;
      stat_q   <= stat_n;
      off_q    <= off_n;
      pf_q     <= pf_in;
      irq      <= stat_n & cfg_n[CFG_PFEN_BIT];
      poweroff <= poweroff | (pd_wr & wdata[PD_OFF_BIT]);
    end
  end

  always_comb begin
    pd_val              = '0;
    pd_val[PD_STAT_BIT] = stat_q;
    pd_val[PD_OFF_BIT]  = off_q;
  end

  // R6
  poweroff_hold_chk: assert property (@(posedge clk) disable iff (rst) poweroff |=> poweroff);
  // R3
  stat_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> ($past(pf_in) && !$past(pf_q)));
  // R5
  clr_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_wr && wdata[PD_CLR_BIT] && pf_in == pf_q) |=> !stat_q);
endmodule

// File: rtl/auxctl_misc.sv
module auxctl_misc
  import auxctl_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int LED_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              diag_wr,
  input  logic              modem_wr,
  input  logic              misc_wr,
  input  logic              led_wr,
  input  logic              sys_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [REG_W-1:0]  diag_q,
  output logic [REG_W-1:0]  modem_q,
  output logic [REG_W-1:0]  misc_q,
  output logic [LED_W-1:0]  led_q,
  output logic [DATA_W-1:0] sys_q,
  output logic              tc_pulse,
  output logic              rst_req
);
  localparam logic [DATA_W-1:0] SYS_LOAD = DATA_W'(1) << SYS_FLAG_BIT;
  logic sys_fire;
  assign sys_fire = sys_wr && wdata[SYS_RST_BIT];

  always_ff @(posedge clk) begin
    if (diag_wr)  diag_q <= wdata[REG_W-1:0];
    if (led_wr)   led_q  <= wdata[LED_W-1:0];
    if (sys_fire) sys_q  <= SYS_LOAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modem_q  <= '0;
      misc_q   <= '0;
      tc_pulse <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (modem_wr) modem_q <= wdata[REG_W-1:0];
      if (misc_wr) begin
        misc_q <= wdata[REG_W-1:0];
        misc_q[MISC_TC_BIT] <= 1'b0;
      end
      tc_pulse <= misc_wr && wdata[MISC_TC_BIT];
      rst_req  <= rst_req | sys_fire;
    end
  end

  // R7
  tc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> $past(misc_wr && wdata[MISC_TC_BIT]));
  // R8
  rst_req_hold_chk: assert property (@(posedge clk) disable iff (rst) rst_req |=> rst_req);
endmodule

// File: rtl/auxctl_regfile.sv
module auxctl_regfile
  import auxctl_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int LED_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_sel,
  input  logic [1:0]        bus_size,
  input  logic [1:0]        bus_off,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_failing,
  output logic              irq_pwrfail,
  output logic              fdd_tc,
  output logic              poweroff_req,
  output logic              sysrst_req
);
  localparam int NREG = NUM_REGS;

  logic [NREG-1:0]   wr_en, rd_en;
  logic [REG_W-1:0]  cfg_q, pd_val, diag_q, modem_q, misc_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic [DATA_W-1:0] rvals [NREG];
  logic [DATA_W-1:0] rmux;

  auxctl_decode #(.NREG(NREG)) u_dec (
    .clk(clk), .rst(rst), .sel(bus_sel), .size(bus_size), .off(bus_off),
    .wr(bus_wr), .rd(bus_rd), .wr_en(wr_en), .rd_en(rd_en)
  );

  auxctl_power #(.REG_W(REG_W)) u_pwr (
    .clk(clk), .rst(rst), .cfg_wr(wr_en[RID_CFG]), .pd_wr(wr_en[RID_PWRDN]),
    .wdata(bus_wdata[REG_W-1:0]), .pf_in(pwr_failing), .cfg_q(cfg_q),
    .pd_val(pd_val), .irq(irq_pwrfail), .poweroff(poweroff_req)
  );

  auxctl_misc #(.REG_W(REG_W), .LED_W(LED_W), .DATA_W(DATA_W)) u_misc (
    .clk(clk), .rst(rst), .diag_wr(wr_en[RID_DIAG]), .modem_wr(wr_en[RID_MODEM]),
    .misc_wr(wr_en[RID_MISC]), .led_wr(wr_en[RID_LED]), .sys_wr(wr_en[RID_SYSCTL]),
    .wdata(bus_wdata), .diag_q(diag_q), .modem_q(modem_q), .misc_q(misc_q),
    .led_q(led_q), .sys_q(sys_q), .tc_pulse(fdd_tc), .rst_req(sysrst_req)
  );

  always_comb begin
    rvals[RID_CFG]    = DATA_W'(cfg_q);
    rvals[RID_DIAG]   = DATA_W'(diag_q);
    rvals[RID_MODEM]  = DATA_W'(modem_q);
    rvals[RID_MISC]   = DATA_W'(misc_q);
    rvals[RID_PWRDN]  = DATA_W'(pd_val);
    rvals[RID_LED]    = DATA_W'(led_q);
    rvals[RID_SYSCTL] = sys_q;
  end

  always_comb begin
    rmux = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_en[i]) rmux = rmux | rvals[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rmux;
  end

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pwrfail |-> (pd_val[PD_STAT_BIT] && cfg_q[CFG_PFEN_BIT]));
  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/auxctl_regfile_tb_top.sv
module auxctl_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bus_sel;
  logic [1:0]  bus_size, bus_off;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        pwr_failing, irq_pwrfail, fdd_tc, poweroff_req, sysrst_req;

  always #10 clk = ~clk;

  auxctl_regfile dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_size(bus_size), .bus_off(bus_off),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_failing(pwr_failing), .irq_pwrfail(irq_pwrfail), .fdd_tc(fdd_tc),
    .poweroff_req(poweroff_req), .sysrst_req(sysrst_req)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_cfg, m_diag, m_modem, m_misc;
  logic [15:0] m_led;
  logic [31:0] m_sys;
  bit m_stat, m_off, m_por, m_rst, m_pfprev;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] req_size(logic [2:0] s);
    if (s == 3'd5) return 2'd1;
    if (s == 3'd6) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] s, logic [1:0] sz, logic [1:0] o);
    if (o != 0 || s == 3'd7 || sz != req_size(s)) return 32'h0;
    case (s)
      3'd0: return {24'h0, m_cfg};
      3'd1: return {24'h0, m_diag};
      3'd2: return {24'h0, m_modem};
      3'd3: return {24'h0, m_misc};
      3'd4: return {26'h0, m_stat, 4'h0, m_off};
      3'd5: return {16'h0, m_led};
      default: return m_sys;
    endcase
  endfunction

  task automatic check_outs(string tag);
    check({tag, " R4 irq"}, {31'h0, irq_pwrfail}, {31'h0, m_stat & m_cfg[3]});
    check({tag, " R6 poweroff"}, {31'h0, poweroff_req}, {31'h0, m_por});
    check({tag, " R8 sysrst"}, {31'h0, sysrst_req}, {31'h0, m_rst});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; pwr_failing = 0; bus_wr = 0; bus_rd = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    m_cfg = 0; m_modem = 0; m_misc = 0; m_stat = 0; m_off = 0;
    m_por = 0; m_rst = 0; m_pfprev = 0;
  endtask

  task automatic do_wr(logic [2:0] s, logic [1:0] sz, logic [1:0] o, logic [31:0] d);
    bit legal, tc;
    @(negedge clk);
    bus_sel = s; bus_size = sz; bus_off = o; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    legal = (o == 0) && (s != 3'd7) && (sz == req_size(s));
    tc = 0;
    if (legal) begin
      case (s)
        3'd0: m_cfg = d[7:0];
        3'd1: m_diag = d[7:0];
        3'd2: m_modem = d[7:0];
        3'd3: begin m_misc = d[7:0] & 8'hFD; tc = d[1]; end
        3'd4: begin m_off = d[0]; if (d[1]) m_stat = 0; if (d[0]) m_por = 1; end
        3'd5: m_led = d[15:0];
        default: if (d[0]) begin m_sys = 32'h2; m_rst = 1; end
      endcase
    end
    @(negedge clk); bus_wr = 0;
    check("R7 tc pulse", {31'h0, fdd_tc}, {31'h0, tc});
    check_outs("wr");
  endtask

  task automatic do_rd(logic [2:0] s, logic [1:0] sz, logic [1:0] o, string tag);
    @(negedge clk);
    bus_sel = s; bus_size = sz; bus_off = o; bus_rd = 1;
    @(posedge clk);
    @(negedge clk); bus_rd = 0;
    check(tag, bus_rdata, exp_read(s, sz, o));
  endtask

  task automatic set_pf(bit v);
    @(negedge clk); pwr_failing = v;
    @(posedge clk);
    if (v != m_pfprev) begin m_stat = v & m_cfg[3]; m_pfprev = v; end
    @(negedge clk);
    check_outs("pf R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; bus_sel = 0; bus_size = 0; bus_off = 0; bus_wr = 0; bus_rd = 0;
    bus_wdata = 0; pwr_failing = 0;
    do_reset();
    // R1 reset state
    check_outs("R1 reset");
    check("R1 tc reset", {31'h0, fdd_tc}, 32'h0);
    do_rd(3'd0, 2'd0, 2'd0, "R1 cfg");
    do_rd(3'd4, 2'd0, 2'd0, "R1 pwrdn");
    // seed kept registers
    do_wr(3'd1, 2'd0, 2'd0, 32'h5A);
    do_wr(3'd5, 2'd1, 2'd0, 32'hBEEF);
    do_wr(3'd6, 2'd2, 2'd0, 32'h1);
    do_rd(3'd6, 2'd2, 2'd0, "R8 sysctl 0x2");
    do_wr(3'd6, 2'd2, 2'd0, 32'hFFFF_FFFE);
    do_rd(3'd6, 2'd2, 2'd0, "R8 bit0 clear no effect");
    do_wr(3'd2, 2'd0, 2'd0, 32'h33);
    do_reset();
    check_outs("R1 reset2");
    do_rd(3'd1, 2'd0, 2'd0, "R2 diag kept");
    do_rd(3'd5, 2'd1, 2'd0, "R2 led kept");
    do_rd(3'd6, 2'd2, 2'd0, "R2 sysctl kept");
    do_rd(3'd2, 2'd0, 2'd0, "R1 modem cleared");
    // sticky power fail
    do_wr(3'd0, 2'd0, 2'd0, 32'h08);
    set_pf(1);
    do_rd(3'd4, 2'd0, 2'd0, "R3 stat set");
    do_wr(3'd0, 2'd0, 2'd0, 32'h00);
    do_rd(3'd4, 2'd0, 2'd0, "R3 sticky with enable off");
    do_wr(3'd0, 2'd0, 2'd0, 32'h08);
    do_wr(3'd4, 2'd0, 2'd0, 32'hFE);
    do_rd(3'd4, 2'd0, 2'd0, "R5 clear bit");
    // misc strobe
    do_wr(3'd3, 2'd0, 2'd0, 32'hFF);
    @(negedge clk);
    check("R7 pulse one cycle", {31'h0, fdd_tc}, 32'h0);
    do_rd(3'd3, 2'd0, 2'd0, "R7 misc bit1 zero");
    // wrong size / offset / code 7
    do_wr(3'd2, 2'd1, 2'd0, 32'hAA);
    do_rd(3'd2, 2'd0, 2'd0, "R10 wrong size write ignored");
    do_rd(3'd2, 2'd2, 2'd0, "R10 wrong size read zero");
    do_wr(3'd5, 2'd1, 2'd2, 32'h1234);
    do_rd(3'd5, 2'd1, 2'd0, "R9 led offset write ignored");
    do_rd(3'd6, 2'd2, 2'd1, "R9 offset read zero");
    do_rd(3'd7, 2'd0, 2'd0, "R11 code7 zero");
    do_wr(3'd4, 2'd0, 2'd0, 32'h01);
    do_wr(3'd4, 2'd0, 2'd0, 32'h00);
    do_rd(3'd4, 2'd0, 2'd0, "R6 off bit cleared but request held");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int unsigned op = $urandom_range(0, 99);
      logic [2:0]  s  = 3'($urandom_range(0, 7));
      logic [1:0]  sz = ($urandom_range(0, 3) == 0) ? 2'($urandom) : req_size(s);
      logic [1:0]  o  = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'd0;
      logic [31:0] d  = $urandom;
      if (s == 3'd6 || s == 3'd4) d[0] = ($urandom_range(0, 15) == 0);
      if (op < 40)      do_wr(s, sz, o, d);
      else if (op < 80) do_rd(s, sz, o, "R12 random read");
      else if (op < 97) set_pf(~m_pfprev);
      else begin
        do_reset();
        check_outs("R1 random reset");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule